// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Sequencer

This block owns the strobes of an asynchronous DRAM during the two phases in which no ordinary traffic runs: bring-up after reset, and the low-power sleep period. After reset it keeps every strobe idle for a settling pause. It then runs a short series of CAS-before-RAS wake-up refreshes and raises `ready` to hand the bus to the normal controller.

While `ready` is high, a `sleep_req` makes the block refresh every row in one burst and then drop into self refresh. It first lowers CAS, then RAS, and holds both low. A `wake_req` is accepted only after RAS has been low longer than the minimum self-refresh time, so the undefined band below that minimum is never used. On exit both strobes rise together. RAS then stays high for at least the exit precharge time, and a second full burst runs before `ready` returns.

All timing is set by parameters in microseconds or nanoseconds plus the clock rate in MHz. A low-power option widens the allowed gap between a burst and the sleep period on either side. The write strobe is held high throughout. The control and status pins are plain levels with no handshake.

Top module: `dram_pwr_seq`

## Requirements
- R1: While reset is asserted, and until the first refresh, `ras_n`, `cas_n` and `we_n` are 1 and `ready` and `asleep` are 0. RAS stays high for more than PAUSE_US×CLK_MHZ cycles after reset is released.
- R2: After the pause, exactly INIT_REFS refresh cycles run, and then `ready` goes high. `ready` is never high before they have completed.
- R3: Every RAS falling edge finds CAS already low from an earlier cycle (CAS-before-RAS), and `we_n` is 1 at every RAS falling edge.
- R4: Inside a burst, each refresh holds RAS low for exactly ceil(RAS_NS×CLK_MHZ/1000) cycles. Between refreshes RAS stays high for at least ceil(PRE_NS×CLK_MHZ/1000)+1 cycles.
- R5: `sleep_req` is sampled only while `ready` is 1. The block then runs BURST_LEN refreshes and enters self refresh: RAS falls with CAS low, both stay low, `asleep` is 1 and `ready` is 0.
- R6: The self-refresh RAS fall comes no more than WIN cycles after the RAS rise of the last burst refresh. WIN is 1560×CLK_MHZ/100, doubled when LOW_POWER is 1.
- R7: In self refresh, `wake_req` has no effect until RAS has been low for more than SR_MIN_US×CLK_MHZ cycles. If `wake_req` is first raised in sleep cycle d+1 (cycle 1 is the first with `asleep` high) and held, the low time is max(SR_MIN_US×CLK_MHZ+1, d+1) cycles. RAS and CAS then rise together.
- R8: After the self-refresh exit, RAS stays high for at least ceil(EXIT_NS×CLK_MHZ/1000) cycles. The next RAS fall comes within WIN cycles of the exit.
- R9: The exit burst has exactly BURST_LEN refreshes. `ready` stays 0 and `asleep` stays 0 during it, and `ready` returns to 1 after it.
- R10: `sleep_req` outside `ready` and `wake_req` outside self refresh cause no refresh and no change of `ready`. If `sleep_req` and `wake_req` arrive together while ready, the sleep is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to refresh all rows and enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| ready | output | 1 | Bus is handed to the normal controller |
| asleep | output | 1 | Device is held in self refresh |

## Verification
Two events can meet in one cycle. The first is a held `wake_req` and the cycle in which the minimum low time runs out. The second is a fresh `sleep_req` and the cycle in which `ready` returns after an exit burst. A stimulus table raises `wake_req` at several offsets after `asleep`: at once, well before the limit, one cycle before it, exactly on it, and long after it. The measured RAS-low width must equal max(limit+1, offset+1) exactly, so an exit one cycle early or late is reported. Each row also starts its sleep in the first cycle that `ready` is seen high again, and some rows raise `wake_req` together with `sleep_req`. The refresh count between request and sleep then shows whether the request was taken and whether the wake was ignored.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_PRE} cbr_phase_e;
  typedef enum logic [2:0] {
    SQ_PAUSE, SQ_INIT, SQ_READY, SQ_PRE_BURST,
    SQ_SR_SETUP, SQ_SLEEP, SQ_EXIT, SQ_POST_BURST
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/dram_pwr_timer.sv
module dram_pwr_timer #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic reached
);
  localparam int unsigned W = $clog2(LIMIT + 2);
  logic [W-1:0] cnt;

  assign reached = (cnt == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (en && !reached)   cnt <= cnt + 1'b1;
  end

  // R7: once the limit is met it is held until cleared
  assert_timer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !clr) |=> reached);
endmodule

// File: rtl/dram_cbr_burst.sv
module dram_cbr_burst
  import dram_pwr_pkg::*;
#(
  parameter int unsigned CW      = 13,
  parameter int unsigned RAS_CYC = 5,
  parameter int unsigned PRE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] len,
  output logic          ras_n,
  output logic          cas_n,
  output logic          done
);
  localparam int unsigned TMAX = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  cbr_phase_e    ph;
  logic [TW-1:0] tmr;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tmr  <= '0;
      left <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          left <= len - 1'b1;
          ph   <= PH_SETUP;
        end
        PH_SETUP: begin
          ph  <= PH_ACT;
          tmr <= TW'(RAS_CYC - 1);
        end
        PH_ACT: if (tmr == '0) begin
          ph  <= PH_PRE;
          tmr <= TW'(PRE_CYC - 1);
        end else tmr <= tmr - 1'b1;
        PH_PRE: if (tmr != '0) tmr <= tmr - 1'b1;
          else if (left == '0) ph <= PH_IDLE;
          else begin
            left <= left - 1'b1;
            ph   <= PH_SETUP;
          end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ras_n = (ph != PH_ACT);
  assign cas_n = !((ph == PH_SETUP) || (ph == PH_ACT));
  assign done  = (ph == PH_PRE) && (tmr == '0) && (left == '0);

  // checker: length of each RAS-low window of a burst refresh
  logic [31:0] act_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_run <= '0;
    else if (ras_n)  act_run <= '0;
    else             act_run <= act_run + 1'b1;
  end

  assert_act_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (act_run == 32'(RAS_CYC)));
endmodule

// File: rtl/dram_pwr_seq.sv
module dram_pwr_seq
  import dram_pwr_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PAUSE_US  = 200,
  parameter int unsigned SR_MIN_US = 100,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned BURST_LEN = 4096,
  parameter int unsigned RAS_NS    = 50,
  parameter int unsigned PRE_NS    = 30,
  parameter int unsigned EXIT_NS   = 90,
  parameter bit          LOW_POWER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready,
  output logic asleep
);
  localparam int unsigned PAUSE_CYC  = PAUSE_US * CLK_MHZ;
  localparam int unsigned SR_MIN_CYC = SR_MIN_US * CLK_MHZ;
  localparam int unsigned RAS_CYC    = ns_to_cyc(RAS_NS, CLK_MHZ);
  localparam int unsigned PRE_CYC    = ns_to_cyc(PRE_NS, CLK_MHZ);
  localparam int unsigned EXIT_CYC   = ns_to_cyc(EXIT_NS, CLK_MHZ);
  localparam int unsigned WIN_CYC    = (LOW_POWER ? 3120 : 1560) * CLK_MHZ / 100;
  localparam int unsigned MAX_LEN    = (BURST_LEN > INIT_REFS) ? BURST_LEN : INIT_REFS;
  localparam int unsigned CW         = $clog2(MAX_LEN + 1);

  seq_state_e    st, nxt;
  logic          go_q, b_done, b_ras_n, b_cas_n;
  logic          pause_done, sr_ok, exit_done;
  logic [CW-1:0] b_len;
  logic          in_burst;

  dram_pwr_timer #(.LIMIT(PAUSE_CYC - 1)) u_pause_tmr (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(st == SQ_PAUSE), .reached(pause_done));

  dram_pwr_timer #(.LIMIT(SR_MIN_CYC)) u_sleep_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st != SQ_SLEEP), .en(st == SQ_SLEEP), .reached(sr_ok));

  dram_pwr_timer #(.LIMIT(EXIT_CYC - 1)) u_exit_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st != SQ_EXIT), .en(st == SQ_EXIT), .reached(exit_done));

  assign b_len = (st == SQ_INIT) ? CW'(INIT_REFS) : CW'(BURST_LEN);

  dram_cbr_burst #(.CW(CW), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(go_q), .len(b_len),
    .ras_n(b_ras_n), .cas_n(b_cas_n), .done(b_done));

  always_comb begin
    nxt = st;
    case (st)
      SQ_PAUSE:      if (pause_done)          nxt = SQ_INIT;
      SQ_INIT:       if (b_done)              nxt = SQ_READY;
      SQ_READY:      if (sleep_req)           nxt = SQ_PRE_BURST;
      SQ_PRE_BURST:  if (b_done)              nxt = SQ_SR_SETUP;
      SQ_SR_SETUP:                            nxt = SQ_SLEEP;
      SQ_SLEEP:      if (sr_ok && wake_req)   nxt = SQ_EXIT;
      SQ_EXIT:       if (exit_done)           nxt = SQ_POST_BURST;
      SQ_POST_BURST: if (b_done)              nxt = SQ_READY;
      default:                                nxt = SQ_PAUSE;
    endcase
  end

  function automatic logic is_burst(input seq_state_e s);
    return (s == SQ_INIT) || (s == SQ_PRE_BURST) || (s == SQ_POST_BURST);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_PAUSE;
      go_q <= 1'b0;
    end else begin
      st   <= nxt;
      go_q <= is_burst(nxt) && (nxt != st);
    end
  end

  assign in_burst = is_burst(st);

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    if (in_burst) begin
      ras_n = b_ras_n;
      cas_n = b_cas_n;
    end else if (st == SQ_SR_SETUP) begin
      cas_n = 1'b0;
    end else if (st == SQ_SLEEP) begin
      ras_n = 1'b0;
      cas_n = 1'b0;
    end
  end

  assign we_n   = 1'b1;
  assign ready  = (st == SQ_READY);
  assign asleep = (st == SQ_SLEEP);

  // checker counters over the pins
  logic [31:0] since_rst, hi_run, lo_run, falls;
  logic        exit_flag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      hi_run    <= '0;
      lo_run    <= '0;
      falls     <= '0;
      exit_flag <= 1'b0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      hi_run <= ras_n ? ((hi_run != '1) ? hi_run + 1'b1 : hi_run) : '0;
      lo_run <= ras_n ? '0 : ((lo_run != '1) ? lo_run + 1'b1 : lo_run);
      if (!ras_n && ($past(ras_n) || since_rst == '0) && falls != '1) falls <= falls + 1'b1;
      if (asleep)      exit_flag <= 1'b1;
      else if (!ras_n) exit_flag <= 1'b0;
    end
  end

  assert_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (since_rst > 32'(PAUSE_CYC)));

  assert_init_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (falls >= 32'(INIT_REFS)));

  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(!cas_n) && we_n));

  assert_entry_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && asleep) |-> (hi_run <= 32'(WIN_CYC)));

  assert_sleep_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && (lo_run < 32'(SR_MIN_CYC))) |=> asleep);

  assert_sleep_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(asleep)) |-> (lo_run > 32'(SR_MIN_CYC)));

  assert_exit_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && exit_flag) |-> ((hi_run >= 32'(EXIT_CYC)) && (hi_run <= 32'(WIN_CYC))));
endmodule

// File: tb/dram_pwr_seq_bench.sv
module dram_pwr_seq_bench;
  localparam int CLK_MHZ = 100, PAUSE_US = 2, SR_MIN_US = 1;
  localparam int INIT_REFS = 8, BURST_LEN = 16;
  // expected values from the requirement formulas
  localparam int E_PAUSE = 200;   // R1: 2 us * 100 MHz
  localparam int E_SRMIN = 100;   // R7: 1 us * 100 MHz
  localparam int E_RAS   = 5;     // R4: ceil(50*100/1000)
  localparam int E_PRE   = 3;     // R4: ceil(30*100/1000)
  localparam int E_EXIT  = 9;     // R8: ceil(90*100/1000)
  localparam int E_WIN   = 1560;  // R6/R8

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic ras_n, cas_n, we_n, ready, asleep;
  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  dram_pwr_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .SR_MIN_US(SR_MIN_US),
    .INIT_REFS(INIT_REFS), .BURST_LEN(BURST_LEN)) u_dram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready), .asleep(asleep));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor
  int falls = 0, hi_run = 0, lo_run = 0, since = 0;
  bit prev_ras = 1'b1, slept = 1'b0, post_exit = 1'b0, first = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      falls = 0; hi_run = 0; lo_run = 0; since = 0;
      prev_ras = 1'b1; slept = 1'b0; post_exit = 1'b0; first = 1'b1;
    end else begin
      since++;
      if (prev_ras && !ras_n) begin
        falls++;
        chk(!cas_n && we_n, "R3 cbr order", {cas_n, we_n}, 2'b01);
        if (first) begin
          chk(since > E_PAUSE, "R1 pause", since, E_PAUSE + 1);
          first = 1'b0;
        end else if (asleep) chk(hi_run <= E_WIN, "R6 entry gap", hi_run, E_WIN);
        else if (post_exit) begin
          chk(hi_run >= E_EXIT && hi_run <= E_WIN, "R8 exit gap", hi_run, E_EXIT);
          post_exit = 1'b0;
        end else chk(hi_run >= E_PRE + 1, "R4 precharge", hi_run, E_PRE + 1);
        hi_run = 0;
      end
      if (!prev_ras && ras_n) begin
        if (slept) post_exit = 1'b1;
        else chk(lo_run == E_RAS, "R4 ras width", lo_run, E_RAS);
        lo_run = 0;
        slept = 1'b0;
      end
      if (ras_n) hi_run++;
      else begin
        lo_run++;
        if (asleep) slept = 1'b1;
      end
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ready(input string req);
    for (int i = 0; i < 4000 && !ready; i++) step();
    chk(ready, req, ready, 1);
  endtask

  // d: cycles after asleep before wake; w: expected RAS-low width;
  // both: wake with sleep; post: sleep pulse during exit burst
  localparam int NROW = 5;
  localparam int TBL [NROW][4] = '{
    '{0,   101, 0, 0},
    '{50,  101, 1, 0},
    '{99,  101, 0, 1},
    '{100, 101, 0, 0},
    '{160, 161, 1, 1}};

  initial begin
    int base, w;
    repeat (3) step();
    chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 3'b111);
    chk(!ready && !asleep, "R1 reset status", {ready, asleep}, 0);
    rst_n = 1'b1;
    repeat (50) step();
    chk(ras_n && cas_n && !ready, "R1 idle in pause", {ras_n, cas_n, ready}, 3'b110);
    sleep_req = 1'b1; wake_req = 1'b1;      // R10: ignored while not ready
    step();
    sleep_req = 1'b0; wake_req = 1'b0;
    wait_ready("R2 ready after init");
    chk(falls == INIT_REFS, "R2 init refresh count", falls, INIT_REFS);
    chk(!asleep, "R2 not asleep", asleep, 0);
    base = falls;
    repeat (30) step();
    chk(falls == base && ready, "R10 sleep_req during init ignored", falls - base, 0);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    repeat (20) step();
    chk(falls == base && ready && !asleep, "R10 wake_req while ready ignored", falls - base, 0);

    for (int r = 0; r < NROW; r++) begin
      base = falls;
      sleep_req = 1'b1;
      wake_req  = TBL[r][2] != 0;
      step();
      sleep_req = 1'b0; wake_req = 1'b0;
      for (int i = 0; i < 4000 && !asleep; i++) step();
      chk(asleep, "R5 asleep reached", asleep, 1);
      chk(falls - base == BURST_LEN + 1, "R5 pre-sleep refresh count", falls - base, BURST_LEN + 1);
      chk(!ready && !ras_n && !cas_n, "R5 strobes held low", {ready, ras_n, cas_n}, 0);
      w = 1;
      for (int i = 0; i < TBL[r][0]; i++) begin
        step();
        if (asleep) w++;
      end
      wake_req = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        step();
        if (!asleep) break;
        w++;
      end
      wake_req = 1'b0;
      chk(w == TBL[r][1], "R7 self-refresh low width", w, TBL[r][1]);
      chk(ras_n && cas_n, "R7 strobes released together", {ras_n, cas_n}, 2'b11);
      if (TBL[r][3] != 0) begin
        for (int i = 0; i < 4000 && falls < base + BURST_LEN + 4; i++) step();
        chk(!ready, "R9 ready low in exit burst", ready, 0);
        sleep_req = 1'b1; step(); sleep_req = 1'b0;   // R10
      end
      wait_ready("R9 ready after exit burst");
      chk(falls - base == 2 * BURST_LEN + 1, "R9 exit refresh count", falls - base, 2 * BURST_LEN + 1);
      chk(!asleep, "R9 not asleep", asleep, 0);
    end
    repeat (20) step();
    chk(ready && ras_n, "R10 idle after last row", {ready, ras_n}, 2'b11);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule